// File: doc/BRIEF.md
# Strobe-Driven Slave FIFO Read Port

This block is the read side of a slave FIFO that an external master reads with asynchronous, active-low strobes: a chip select, an output enable, a read strobe and a FIFO-select line. A fast internal clock samples every strobe through a two-flop synchronizer, and all edges are detected in that clock domain. Behind the port sit two independent word FIFOs, chosen by the select line. Each FIFO has its own read pointer, write pointer, fill count and output data latch. A simple synchronous push port fills the FIFOs for test.

The output data and its drive enable go to a tri-state pad. While output enable is asserted, the pad carries the latch of the selected FIFO. On its own, output enable therefore shows the word from the previous read. A read strobe, qualified by chip select, copies the current head word into the latch. The read pointer moves on only when the strobe is released. Back-to-back strobe pulses with output enable held low give consecutive words, and the bus stays driven between them. The port also flags strobe pulses that are too short, a select line that moves during a read, and reads from an empty FIFO.

Top module: `sfifo_rd_port`

## Requirements
- R1: `dq_oe` equals the inverse of `oe_n` as sampled two clock edges earlier. While `dq_oe` is 0 the pad is high-impedance.
- R2: With output enable active and no read strobe, `dq_o` carries the latch of the FIFO picked by `fsel` (0 or 1). That latch holds the last word read from that FIFO, or 0 after reset.
- R3: A read starts only if chip select is active in the same synchronized sample as the rising read strobe, or earlier. A strobe that begins before chip select leaves the latch and the pointer unchanged.
- R4: A started read loads the head word into the latch, and `dq_o` shows it three clock edges after `rd_n` falls. The pointer advances when the strobe is released, and `empty` reflects this three edges after `rd_n` rises. Successive reads return successive words in push order.
- R5: The port gives the same data when `oe_n` and `rd_n` are driven together as one signal.
- R6: `width_err` is set if the synchronized strobe stays active for fewer than MIN_ACT cycles, or stays inactive between pulses for fewer than MIN_INACT cycles. It stays set until reset.
- R7: `addr_err` is set if the synchronized `fsel` changes while a strobe is active, or within HOLD cycles after the strobe ends. It stays set until reset.
- R8: In a burst with output enable held active, `dq_oe` stays 1 throughout, and each strobe pulse presents the next word. That word holds until the next pulse loads.
- R9: A read strobe on an empty FIFO leaves its latch and pointer unchanged and sets that FIFO's sticky bit in `underflow` (bit i for FIFO i). The other FIFO's bit is not affected.
- R10: The two FIFOs are independent. Pushes and reads on one never change the other's data order, latch or `empty` bit.
- R11: After reset, `empty` is all ones, `dq_oe` is 0, and `underflow`, `width_err` and `addr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Test fill: write `push_data` this cycle; ignored when that FIFO is full |
| push_sel | input | SW | Test fill: target FIFO |
| push_data | input | DW | Test fill: word to write |
| cs_n | input | 1 | Asynchronous chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_n | input | 1 | Asynchronous read strobe, active low |
| fsel | input | SW | Asynchronous FIFO select |
| dq_o | output | DW | Data toward the pad |
| dq_oe | output | 1 | Pad drive enable; 0 means high-impedance |
| empty | output | NF | Per-FIFO empty flag |
| underflow | output | NF | Per-FIFO sticky read-while-empty flag |
| width_err | output | 1 | Sticky strobe width violation |
| addr_err | output | 1 | Sticky select-stability violation |

## Verification
Inputs change just after a falling clock edge, so every latency below is a whole number of rising edges, and the bench samples at the falling edge after the due edge. The drive enable is due two edges after `oe_n` changes. A new latch word is due three edges after `rd_n` falls, and the empty flag three edges after `rd_n` rises. Both error flags are due three edges after the offending input change. The bench waits exactly those counts before each check. During bursts it also checks the drive enable and data at every falling edge between pulses, which confirms the bus has no gap.

// File: rtl/sfifo_rd_port.sv
module sfifo_rd_port #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int NF        = 2,
  parameter int MIN_ACT   = 3,
  parameter int MIN_INACT = 3,
  parameter int HOLD      = 2,
  localparam int SW       = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [SW-1:0] push_sel,
  input  logic [DW-1:0] push_data,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          rd_n,
  input  logic [SW-1:0] fsel,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [NF-1:0] empty,
  output logic [NF-1:0] underflow,
  output logic          width_err,
  output logic          addr_err
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int MAXW = (MIN_ACT > MIN_INACT) ? MIN_ACT : MIN_INACT;
  localparam int TW   = $clog2(MAXW + 1) + 1;
  localparam int HW   = $clog2(HOLD + 1) + 1;

  logic [1:0] cs_m, oe_m, rd_m;
  logic [SW-1:0] fsel_m, fsel_s, fsel_q;
  logic rd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m <= '0; oe_m <= '0; rd_m <= '0; rd_q <= 1'b0;
      fsel_m <= '0; fsel_s <= '0; fsel_q <= '0;
    end else begin
      cs_m <= {cs_m[0], ~cs_n};
      oe_m <= {oe_m[0], ~oe_n};
      rd_m <= {rd_m[0], ~rd_n};
      rd_q <= rd_m[1];
      fsel_m <= fsel;
      fsel_s <= fsel_m;
      fsel_q <= fsel_s;
    end
  end

  wire cs_s    = cs_m[1];
  wire oe_s    = oe_m[1];
  wire rd_s    = rd_m[1];
  wire rd_rise = rd_s & ~rd_q;
  wire rd_fall = ~rd_s & rd_q;

  logic [NF-1:0][DW-1:0] lat_all;
  logic [NF-1:0][CW-1:0] cnt_all;
  wire sel_empty = empty[fsel_s];
  wire start     = rd_rise & cs_s & ~sel_empty;
  wire uf_hit    = rd_rise & cs_s & sel_empty;

  logic act;
  logic [SW-1:0] act_sel;
  wire pop = rd_fall & act;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; act_sel <= '0;
    end else if (start) begin
      act <= 1'b1; act_sel <= fsel_s;
    end else if (rd_fall) begin
      act <= 1'b0;
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [DW-1:0] lat;
    wire wr = push_valid & (push_sel == SW'(i)) & (cnt < CW'(DEPTH));
    wire rd = pop & (act_sel == SW'(i));
    wire ld = start & (fsel_s == SW'(i));
    always_ff @(posedge clk) if (wr) mem[wp] <= push_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0; lat <= '0;
      end else begin
        if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(wr) - CW'(rd);
        if (ld) lat <= mem[rp];
      end
    end
    assign lat_all[i] = lat;
    assign cnt_all[i] = cnt;
    assign empty[i]   = (cnt == '0);
  end

  logic [TW-1:0] hi_cnt, lo_cnt;
  logic seen;
  logic [HW-1:0] hold_cnt;
  wire sel_moved = (fsel_s != fsel_q) & (rd_s | rd_q | (hold_cnt != '0));
  wire short_hi  = rd_fall & (hi_cnt < TW'(MIN_ACT));
  wire short_lo  = rd_rise & seen & (lo_cnt < TW'(MIN_INACT));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0; lo_cnt <= '0; seen <= 1'b0; hold_cnt <= '0;
      width_err <= 1'b0; addr_err <= 1'b0; underflow <= '0;
    end else begin
      if (rd_rise) hi_cnt <= TW'(1);
      else if (rd_s && hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (rd_fall) lo_cnt <= TW'(1);
      else if (!rd_s && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (rd_fall) seen <= 1'b1;
      if (rd_fall) hold_cnt <= HW'(HOLD);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (short_hi || short_lo) width_err <= 1'b1;
      if (sel_moved) addr_err <= 1'b1;
      if (uf_hit) underflow <= underflow | (NF'(1) << fsel_s);
    end
  end

  assign dq_o  = lat_all[fsel_s];
  assign dq_oe = oe_s;
endmodule

module sfifo_rd_port_chk #(
  parameter int DW = 8, DEPTH = 16, NF = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic clk, rst_n, oe_n, dq_oe, rd_s, rd_q, width_err, addr_err,
  input logic [NF-1:0] underflow,
  input logic [NF-1:0][DW-1:0] lat_all,
  input logic [NF-1:0][CW-1:0] cnt_all
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;

  assert_oe_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (dq_oe == !$past(oe_n, 2)));
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && rd_q) |=> $stable(lat_all));
  assert_uf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |-> ((underflow & $past(underflow)) == $past(underflow)));
  assert_werr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(width_err) |=> width_err);
  assert_aerr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err) |=> addr_err);
  for (genvar i = 0; i < NF; i++) begin : g_bound
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_all[i] <= CW'(DEPTH));
  end
endmodule

bind sfifo_rd_port sfifo_rd_port_chk #(.DW(DW), .DEPTH(DEPTH), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dq_oe(dq_oe), .rd_s(rd_s), .rd_q(rd_q),
  .width_err(width_err), .addr_err(addr_err), .underflow(underflow),
  .lat_all(lat_all), .cnt_all(cnt_all)
);

// File: tb/test_sfifo_rd_port.sv
`timescale 1ns/1ps
module test_sfifo_rd_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [0:0] push_sel = '0, fsel = '0;
  logic [7:0] push_data = '0;
  logic cs_n = 1'b1, oe_n = 1'b1, rd_n = 1'b1;
  logic [7:0] dq_o;
  logic dq_oe, width_err, addr_err;
  logic [1:0] empty, underflow;
  int n_chk = 0, n_fail = 0;
  logic [7:0] prev [2] = '{8'h00, 8'h00};

  always #2 clk = ~clk;

  sfifo_rd_port i_sfifo_rd_port (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_sel(push_sel),
    .push_data(push_data), .cs_n(cs_n), .oe_n(oe_n), .rd_n(rd_n), .fsel(fsel),
    .dq_o(dq_o), .dq_oe(dq_oe), .empty(empty), .underflow(underflow),
    .width_err(width_err), .addr_err(addr_err));

  // {fsel, tied, expected word, empty after}
  localparam logic [10:0] VEC [7] = '{
    {1'b0, 1'b0, 8'h10, 1'b0}, {1'b1, 1'b0, 8'hA0, 1'b0},
    {1'b0, 1'b1, 8'h11, 1'b0}, {1'b0, 1'b0, 8'h12, 1'b0},
    {1'b1, 1'b1, 8'hA1, 1'b0}, {1'b1, 1'b0, 8'hA2, 1'b1},
    {1'b0, 1'b0, 8'h13, 1'b1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic s, input logic [7:0] d);
    @(negedge clk); push_valid = 1'b1; push_sel = s; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic read_op(input logic s, input logic tied, input logic [7:0] exp,
                         input logic exp_empty, input logic update);
    @(negedge clk); fsel = s;
    if (!tied) begin
      cs_n = 1'b0; oe_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(dq_oe == 1'b1, "R1 drive on", dq_oe, 1);
      chk(dq_o == prev[s], "R2 previous word", dq_o, prev[s]);
    end
    @(negedge clk); rd_n = 1'b0; oe_n = 1'b0; cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dq_o == exp, tied ? "R5 tied read" : "R4 read word", dq_o, exp);
    chk(dq_oe == 1'b1, "R1 drive in read", dq_oe, 1);
    @(negedge clk); rd_n = 1'b1; if (tied) oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(empty[s] == exp_empty, "R4 empty after read", empty[s], exp_empty);
    if (tied) chk(dq_oe == 1'b0, "R5 tied release", dq_oe, 0);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dq_oe == 1'b0, "R1 high-Z", dq_oe, 0);
    if (update) prev[s] = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 2'b11, "R11 empty", empty, 3);
    chk(dq_oe == 1'b0, "R11 dq_oe", dq_oe, 0);
    chk({underflow, width_err, addr_err} == '0, "R11 flags",
        {underflow, width_err, addr_err}, 0);

    for (int i = 0; i < 4; i++) push(1'b0, 8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) push(1'b1, 8'hA0 + 8'(i));
    @(negedge clk);
    chk(empty == 2'b00, "R10 both filled", empty, 0);

    for (int k = 0; k < 7; k++)
      read_op(VEC[k][10], VEC[k][9], VEC[k][8:1], VEC[k][0], 1'b1);
    chk(width_err == 1'b0, "R6 no false width error", width_err, 0);
    chk(addr_err == 1'b0, "R7 no false address error", addr_err, 0);

    // R3: strobe before chip select does not read
    push(1'b0, 8'h55);
    @(negedge clk); fsel = 1'b0; oe_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    repeat (3) @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dq_o == 8'h13, "R3 late select ignored", dq_o, 8'h13);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(empty[0] == 1'b0, "R3 pointer kept", empty[0], 0);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    read_op(1'b0, 1'b0, 8'h55, 1'b1, 1'b1);

    // R9: read of empty FIFO 0
    read_op(1'b0, 1'b0, 8'h55, 1'b1, 1'b0);
    chk(underflow == 2'b01, "R9 underflow bit", underflow, 1);

    // R8: burst on FIFO 1
    for (int i = 0; i < 3; i++) push(1'b1, 8'hC0 + 8'(i));
    @(negedge clk); fsel = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      rd_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(dq_o == 8'hC0 + 8'(k), "R8 burst word", dq_o, 8'hC0 + 8'(k));
      @(negedge clk); rd_n = 1'b1;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(dq_oe == 1'b1 && dq_o == 8'hC0 + 8'(k), "R8 no gap", dq_o, 8'hC0 + 8'(k));
      end
      @(negedge clk);
    end
    chk(empty[1] == 1'b1, "R8 burst drained", empty[1], 1);
    chk(underflow == 2'b01, "R10 FIFO 1 no underflow", underflow, 1);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: one-cycle strobe
    push(1'b1, 8'h66);
    @(negedge clk); fsel = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(width_err == 1'b1, "R6 short strobe", width_err, 1);
    chk(addr_err == 1'b0, "R7 still clear", addr_err, 0);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: select moves during a read
    push(1'b0, 8'h77);
    @(negedge clk); fsel = 1'b0; cs_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dq_o == 8'h77, "R4 word before select move", dq_o, 8'h77);
    fsel = 1'b1;
    repeat (3) @(negedge clk);
    chk(addr_err == 1'b1, "R7 select moved", addr_err, 1);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(empty[0] == 1'b1, "R4 pop uses start select", empty[0], 1);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(width_err && addr_err, "R6 R7 sticky", {width_err, addr_err}, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule